// File: doc/BRIEF.md
# Multi-Chip Memory Array Composer

This block assembles one wide, deep, byte-addressed memory from a grid of identical small storage chips. The chips have depth D and width W. The requested memory has M words of N bits. The chips sit in M/D rows and N/W columns, which makes (M·N)/(D·W) chips in total. All chips in one row work together. Each column supplies its own W-bit slice of the N-bit word.

A requester presents a byte address, an access size and a direction, and waits while the block reports `busy`. The address is cut into three fields:

- The lowest log2(N/8) bits pick a byte lane. They never reach the chips.
- The next log2(D) bits form the in-chip address, which is fanned out to every chip.
- The bits above that choose the row.

Under full decoding, every address bit above the row field must be zero, so each location has exactly one address. Under partial decoding those bits are ignored, and the memory repeats at alias addresses. Every access must also be naturally aligned to its size. An access that is misaligned, wider than the word, or unmapped is refused outright and is never split.

The sequencer walks through these states:

- IDLE. It leaves IDLE on a request (accept), going to CHECK.
- CHECK. It goes to FAULT (reject), to WRITE (write granted) or to READ (read granted).
- WRITE. It returns to IDLE.
- READ. It moves to RESP.
- RESP. It returns to IDLE.
- FAULT. It returns to IDLE.

Top module: `mem_array_composer`

## Requirements
- R1: With the default sizes (64 words of 32 bits from 16x16 chips), the memory is 4 rows by 2 columns, and every one of the 64 word locations keeps an independent value written with a 4-byte write.
- R2: Address bits [1:0] select only the byte lane. A read of any size returns the full 32-bit word at word index addr[7:2].
- R3: Address bits [5:2] are the in-chip address and are applied to every chip of the selected row.
- R4: Address bits [7:6] select exactly one row. At no time is more than one row enabled.
- R5: With `full_decode`=1, an access with any of address bits [15:8] nonzero is rejected with `err`, and no location changes.
- R6: With `full_decode`=0, address bits [15:8] are ignored, so an address aliases to the word given by bits [7:2].
- R7: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. A 2-byte access needs addr[0]=0, a 4-byte access needs addr[1:0]=0, and an 8-byte access needs addr[2:0]=0. A misaligned access raises `err` and writes nothing.
- R8: An access wider than the word (size code 3 with a 32-bit word) is rejected with `err`, even when it is aligned.
- R9: Counting from the clock edge that accepts a request, `err` or `wr_ack` is high during the second cycle and `rd_valid` during the third. Each is a single-cycle pulse, and at most one of them is high at a time.
- R10: A narrow write changes only the addressed byte lanes. It uses bus lanes addr[1:0] up to addr[1:0]+size bytes-1 of `wdata`.
- R11: A request is accepted only while `busy` is low. Requests presented while busy have no effect.
- R12: After reset, `busy`, `err`, `wr_ack` and `rd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| full_decode | input | 1 | 1 = full decoding of upper bits, 0 = partial decoding |
| req | input | 1 | Request, sampled while not busy |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size code (log2 of byte count) |
| addr | input | ADDR_W | Byte address |
| wdata | input | WORD_W | Write data on byte lanes |
| busy | output | 1 | Sequencer is not idle |
| wr_ack | output | 1 | Write performed (one cycle) |
| rd_valid | output | 1 | `rdata` is valid (one cycle) |
| rdata | output | WORD_W | Full read word |
| err | output | 1 | Access rejected (one cycle) |

## Verification
Alignment refusal and full-decode range refusal can both apply to one access, and either can also coincide with a request that is too wide. The bench provokes these combinations with a random stream that mixes misaligned offsets, all four size codes and addresses with nonzero upper bits. It also drives directed accesses, such as a misaligned halfword to an unmapped address. For every such access it expects one error pulse at the fixed latency, and it confirms by later reads that no location was touched. A second overlap is a new request arriving while an access is still in flight. This is judged the same way: the intruding write's target location is read back unchanged.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_READ,
        ST_RESP,
        ST_FAULT
    } mac_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } mac_size_t;

endpackage

// File: rtl/mac_addr_split.sv
module mac_addr_split #(
    parameter int ADDR_W     = 16,
    parameter int WORD_BYTES = 4,
    parameter int CHIP_DEPTH = 16,
    parameter int ROWS       = 4
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [1:0]                          size,
    input  logic                                full_decode,
    output logic [$clog2(CHIP_DEPTH)-1:0]       in_addr,
    output logic [$clog2(ROWS)-1:0]             row_idx,
    output logic [ROWS-1:0]                     row_hot,
    output logic [WORD_BYTES-1:0]               lane_en,
    output logic                                aligned,
    output logic                                fits,
    output logic                                mapped
);
    localparam int LANE_BITS = $clog2(WORD_BYTES);
    localparam int IN_BITS   = $clog2(CHIP_DEPTH);
    localparam int ROW_BITS  = $clog2(ROWS);
    localparam int IN_LSB    = LANE_BITS;
    localparam int ROW_LSB   = LANE_BITS + IN_BITS;
    localparam int HI_LSB    = ROW_LSB + ROW_BITS;

    logic [3:0] span;
    logic [3:0] span_m1;
    int         lane_off;

    always_comb begin
        span     = 4'd1 << size;
        span_m1  = span - 4'd1;
        fits     = (int'(span) <= WORD_BYTES);
        aligned  = ((addr[2:0] & span_m1[2:0]) == 3'b000);
        mapped   = !full_decode || (addr[ADDR_W-1:HI_LSB] == '0);
        in_addr  = addr[IN_LSB +: IN_BITS];
        row_idx  = addr[ROW_LSB +: ROW_BITS];
        lane_off = int'(addr[LANE_BITS-1:0]);
        for (int r = 0; r < ROWS; r++) begin
            row_hot[r] = (int'(row_idx) == r);
        end
        for (int b = 0; b < WORD_BYTES; b++) begin
            lane_en[b] = (b >= lane_off) && (b < lane_off + int'(span));
        end
    end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we_q,
    input  logic ok,
    output logic load,
    output logic do_write,
    output logic do_read,
    output logic wr_ack,
    output logic rd_valid,
    output logic err,
    output logic busy
);
    mac_state_t state;
    mac_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (!ok)       state_nx = ST_FAULT;
                else if (we_q) state_nx = ST_WRITE;
                else           state_nx = ST_READ;
            end
            ST_WRITE: state_nx = ST_IDLE;
            ST_READ:  state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        do_write = 1'b0;
        do_read  = 1'b0;
        wr_ack   = 1'b0;
        rd_valid = 1'b0;
        err      = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = req;
            end
            ST_CHECK: ;
            ST_WRITE: begin
                do_write = 1'b1;
                wr_ack   = 1'b1;
            end
            ST_READ:  do_read  = 1'b1;
            ST_RESP:  rd_valid = 1'b1;
            ST_FAULT: err      = 1'b1;
            default:  busy     = 1'b1;
        endcase
    end

endmodule

// File: rtl/mac_chip.sv
module mac_chip #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     sel,
    input  logic                     wr,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH/8-1:0]       ben,
    input  logic [WIDTH-1:0]         din,
    output logic [WIDTH-1:0]         dout
);
    localparam int NB = WIDTH / 8;

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (sel && wr) begin
            for (int b = 0; b < NB; b++) begin
                if (ben[b]) cells[addr][b*8 +: 8] <= din[b*8 +: 8];
            end
        end
        if (sel && !wr) dout <= cells[addr];
    end

endmodule

// File: rtl/mem_array_composer.sv
module mem_array_composer #(
    parameter int ADDR_W      = 16,
    parameter int TOTAL_WORDS = 64,
    parameter int WORD_W      = 32,
    parameter int CHIP_DEPTH  = 16,
    parameter int CHIP_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_decode,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              busy,
    output logic              wr_ack,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rdata,
    output logic              err
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int ROWS       = TOTAL_WORDS / CHIP_DEPTH;
    localparam int COLS       = WORD_W / CHIP_W;
    localparam int CHIP_BYTES = CHIP_W / 8;
    localparam int IN_BITS    = $clog2(CHIP_DEPTH);
    localparam int ROW_BITS   = $clog2(ROWS);

    logic              q_we;
    logic [1:0]        q_size;
    logic [ADDR_W-1:0] q_addr;
    logic [WORD_W-1:0] q_wdata;
    logic              q_full;

    logic                  load, do_write, do_read, ok;
    logic [IN_BITS-1:0]    in_addr;
    logic [ROW_BITS-1:0]   row_idx;
    logic [ROWS-1:0]       row_hot;
    logic [ROWS-1:0]       row_cs;
    logic                  chip_we;
    logic [WORD_BYTES-1:0] lane_en;
    logic                  aligned, fits, mapped;
    logic [WORD_W-1:0]     row_rdata [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_we    <= 1'b0;
            q_size  <= 2'd0;
            q_addr  <= '0;
            q_wdata <= '0;
            q_full  <= 1'b1;
        end else if (load) begin
            q_we    <= we;
            q_size  <= size;
            q_addr  <= addr;
            q_wdata <= wdata;
            q_full  <= full_decode;
        end
    end

    mac_addr_split #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .CHIP_DEPTH (CHIP_DEPTH),
        .ROWS       (ROWS)
    ) u_split (
        .addr        (q_addr),
        .size        (q_size),
        .full_decode (q_full),
        .in_addr     (in_addr),
        .row_idx     (row_idx),
        .row_hot     (row_hot),
        .lane_en     (lane_en),
        .aligned     (aligned),
        .fits        (fits),
        .mapped      (mapped)
    );

    assign ok = aligned && fits && mapped;

    mac_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we_q     (q_we),
        .ok       (ok),
        .load     (load),
        .do_write (do_write),
        .do_read  (do_read),
        .wr_ack   (wr_ack),
        .rd_valid (rd_valid),
        .err      (err),
        .busy     (busy)
    );

    assign row_cs  = row_hot & {ROWS{do_write | do_read}};
    assign chip_we = do_write;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            mac_chip #(
                .DEPTH (CHIP_DEPTH),
                .WIDTH (CHIP_W)
            ) u_chip (
                .clk  (clk),
                .sel  (row_cs[r]),
                .wr   (chip_we),
                .addr (in_addr),
                .ben  (lane_en[c*CHIP_BYTES +: CHIP_BYTES]),
                .din  (q_wdata[c*CHIP_W +: CHIP_W]),
                .dout (row_rdata[r][c*CHIP_W +: CHIP_W])
            );
        end
    end

    assign rdata = row_rdata[row_idx];

endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int ROWS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            busy,
    input logic            err,
    input logic            wr_ack,
    input logic            rd_valid,
    input logic [ROWS-1:0] row_cs,
    input logic            chip_we
);
    p_single_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_cs));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    p_err_no_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (row_cs == '0));

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err, wr_ack, rd_valid}));

    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req) |=> !busy);

    p_read_before_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past((row_cs != '0) && !chip_we));

endmodule

bind mem_array_composer mac_checker #(.ROWS(ROWS)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .busy     (busy),
    .err      (err),
    .wr_ack   (wr_ack),
    .rd_valid (rd_valid),
    .row_cs   (row_cs),
    .chip_we  (chip_we)
);

// File: tb/mem_array_composer_test.sv
module mem_array_composer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        full_decode = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        busy, wr_ack, rd_valid, err;
    logic [31:0] rdata;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    logic [7:0] bm [256];

    always #5 clk = ~clk;

    mem_array_composer uut (
        .clk(clk), .rst_n(rst_n), .full_decode(full_decode), .req(req),
        .we(we), .size(size), .addr(addr), .wdata(wdata), .busy(busy),
        .wr_ack(wr_ack), .rd_valid(rd_valid), .rdata(rdata), .err(err)
    );

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ok(input logic [15:0] a, input logic [1:0] sz, input bit full);
        int n = 1 << sz;
        if (n > 4) return 1'b0;
        if ((int'(a[2:0]) & (n - 1)) != 0) return 1'b0;
        if (full && a[15:8] != 8'h00) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string exp_tag(input logic [15:0] a, input logic [1:0] sz, input bit full, input bit w);
        int n = 1 << sz;
        if (n > 4) return "R8";
        if ((int'(a[2:0]) & (n - 1)) != 0) return "R7";
        if (full && a[15:8] != 8'h00) return "R5";
        return w ? "R10" : "R3";
    endfunction

    function automatic logic [31:0] model_word(input logic [15:0] a);
        int base = int'(a[7:2]) * 4;
        return {bm[base+3], bm[base+2], bm[base+1], bm[base]};
    endfunction

    task automatic op(input bit w, input logic [1:0] sz, input logic [15:0] a,
                      input logic [31:0] wd, input bit full, input bit intrude, input string tag);
        int lat;
        bit e, ack, rv;
        logic [31:0] rd;
        bit good = exp_ok(a, sz, full);
        e = 0; ack = 0; rv = 0; rd = '0;
        @(negedge clk);
        req = 1; we = w; size = sz; addr = a; wdata = wd; full_decode = full;
        @(posedge clk);
        @(negedge clk);
        if (intrude) begin
            we = 1; size = 2'd2; addr = a ^ 16'h0004; wdata = ~wd; full_decode = 0;
        end else begin
            req = 0;
        end
        lat = 1;
        while (lat < 8) begin
            if (err || wr_ack || rd_valid) break;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        e = err; ack = wr_ack; rv = rd_valid; rd = rdata;
        req = 0;
        if (!good) begin
            chk(e && !ack && !rv, tag, {61'd0, e, ack, rv}, 64'h4);
            chk(lat == 2, "R9", lat, 2);
        end else if (w) begin
            chk(ack && !e, tag, {61'd0, e, ack, rv}, 64'h2);
            chk(lat == 2, "R9", lat, 2);
            for (int k = int'(a[1:0]); k < int'(a[1:0]) + (1 << sz); k++)
                bm[int'(a[7:2]) * 4 + k] = wd[k*8 +: 8];
        end else begin
            chk(rv && !e, tag, {61'd0, e, ack, rv}, 64'h1);
            chk(lat == 3, "R9", lat, 3);
            chk(rd == model_word(a), tag, rd, model_word(a));
        end
        @(posedge clk);
        @(negedge clk);
        chk(!err && !wr_ack && !rd_valid && !busy, "R9", {60'd0, err, wr_ack, rd_valid, busy}, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_sink;
        seed_sink = $urandom(32'd20250);
        for (int i = 0; i < 256; i++) bm[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk(!busy && !err && !wr_ack && !rd_valid, "R12",
            {60'd0, busy, err, wr_ack, rd_valid}, 0);
        rst_n = 1;

        // R1: fill every row and column, then read back all words
        for (int w = 0; w < 64; w++)
            op(1, 2'd2, 16'(w * 4), 32'hA5000000 ^ (32'(w) * 32'h01030507), 1, 0, "R1");
        for (int w = 0; w < 64; w++)
            op(0, 2'd2, 16'(w * 4), 0, 1, 0, "R1");

        // R2: byte read at lane 3 returns whole word
        op(0, 2'd0, 16'h0013, 0, 1, 0, "R2");
        op(0, 2'd1, 16'h00E2, 0, 1, 0, "R2");
        // R4: rows selected by bits [7:6]
        op(0, 2'd2, 16'h00C0, 0, 1, 0, "R4");
        // R7: misaligned half / word / double, then confirm no change
        op(1, 2'd1, 16'h0021, 32'hDEADBEEF, 1, 0, "R7");
        op(1, 2'd2, 16'h0006, 32'hDEADBEEF, 1, 0, "R7");
        op(1, 2'd3, 16'h000C, 32'hDEADBEEF, 1, 0, "R7");
        op(0, 2'd2, 16'h0020, 0, 1, 0, "R7");
        op(0, 2'd2, 16'h0004, 0, 1, 0, "R7");
        // R8: aligned 8-byte access is too wide
        op(1, 2'd3, 16'h0010, 32'h12345678, 1, 0, "R8");
        op(0, 2'd2, 16'h0010, 0, 1, 0, "R8");
        // R5: unmapped under full decoding; also misaligned at the same time
        op(1, 2'd2, 16'h0104, 32'h0BADF00D, 1, 0, "R5");
        op(1, 2'd1, 16'h8009, 32'h0BADF00D, 1, 0, "R5");
        op(0, 2'd2, 16'h0004, 0, 1, 0, "R5");
        op(0, 2'd2, 16'h0008, 0, 1, 0, "R5");
        // R6: alias under partial decoding
        op(1, 2'd2, 16'h3F08, 32'hCAFE0123, 0, 0, "R6");
        op(0, 2'd2, 16'h0008, 0, 1, 0, "R6");
        op(0, 2'd2, 16'hFF08, 0, 0, 0, "R6");
        // R10: narrow writes touch only addressed lanes
        op(1, 2'd0, 16'h0031, 32'h0000EE00, 1, 0, "R10");
        op(1, 2'd1, 16'h0036, 32'h77660000, 1, 0, "R10");
        op(0, 2'd2, 16'h0030, 0, 1, 0, "R10");
        op(0, 2'd2, 16'h0034, 0, 1, 0, "R10");
        // R11: request held while busy is ignored
        op(1, 2'd2, 16'h0040, 32'h13579BDF, 1, 1, "R11");
        op(0, 2'd2, 16'h0044, 0, 1, 0, "R11");
        op(0, 2'd2, 16'h0040, 0, 1, 0, "R11");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [1:0]  sz;
            bit          w, full, intr;
            a    = 16'($urandom);
            if ($urandom % 3 != 0) a[15:8] = 8'h00;
            sz   = 2'($urandom % 4);
            if ($urandom % 2 == 0) a[2:0] = a[2:0] & ~(3'((1 << sz) - 1));
            w    = 1'($urandom % 2);
            full = 1'($urandom % 2);
            intr = ($urandom % 8 == 0);
            op(w, sz, a, $urandom, full, intr, exp_tag(a, sz, full, w));
            if (intr) op(0, 2'd2, a ^ 16'h0004, 0, 0, 0, "R11");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule